// File: doc/BRIEF.md
# Nonvolatile Setting Commit Controller

This block holds the settings of three digitally programmed resistor channels. Each setting is one byte. The low seven bits give a tap position from 0 to 127. The top bit switches the channel into a high-impedance state, so a channel can also serve as an open-drain style switch: code 00h gives a driven low and code 80h lets an external pull-up take the line high. A serial-bus front end, which lies outside this block, passes decoded register writes, register reads and a bus-stop pulse to it.

A write is not applied as soon as the data byte arrives. The block keeps it in a single pending slot. When the bus-stop pulse comes, it starts a timed commit to a backing store that models nonvolatile memory. For the whole commit it raises `busy` and ignores all bus-side input. When the commit ends, the active setting and the stored copy both take the new value together. On every system reset the block reloads the active settings from the backing store. A separate power-on clear sets the store to its blank value, which models first power-up of an unprogrammed part.

Top module: `nv_setting_commit`

## Requirements
- R1: Pointers F8h, F9h and FAh select channels 0, 1 and 2. A read of one of these pointers returns the full 8-bit active value of its channel, bit 7 included, in the same cycle.
- R2: Channel c drives `tap_pos[c*7 +: 7]` from bits 6:0 of its active value and drives `hiz[c]` from bit 7.
- R3: An active value of 00h gives tap 0 with `hiz` low. 7Fh gives tap 127 with `hiz` low. Any value of 80h or above sets `hiz` high.
- R4: An accepted write leaves the tap outputs, `hiz` and readback unchanged until its commit ends. There is one pending slot, and each newer in-range write replaces the older one.
- R5: If `bus_stop` is sampled while idle with a write pending, `busy` rises at that same clock edge and stays high for exactly COMMIT_CYCLES cycles. When `busy` falls, the active value and the backing store both hold the pending value.
- R6: While `busy` is high, `wr_en` and `bus_stop` are ignored. No write is captured and no further commit follows.
- R7: A write to a pointer outside F8h..FAh is discarded, and the stop that follows starts no commit. A read of such a pointer returns 00h.
- R8: A `bus_stop` with no write pending leaves `busy` low and changes nothing.
- R9: While `rst_n` is low, `busy` is high and all tap and `hiz` outputs are zero. At the first clock edge after release, the active values are reloaded from the backing store and `busy` falls. The store keeps its contents through `rst_n`.
- R10: While `por_n` is low, the backing store is cleared to FFh. After the recall that follows, every channel reads FFh (tap 127, `hiz` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset; starts a recall from the store |
| por_n | input | 1 | Active-low power-on clear of the backing store |
| wr_en | input | 1 | One-cycle register write strobe from the bus front end |
| wr_ptr | input | 8 | Register pointer of the write |
| wr_data | input | 8 | Setting byte to write |
| bus_stop | input | 1 | One-cycle pulse marking a bus stop condition |
| rd_ptr | input | 8 | Register pointer for readback |
| rd_data | output | 8 | Active value of the addressed channel, or 00h |
| busy | output | 1 | High during recall and during a commit |
| tap_pos | output | 21 | Tap positions, 7 bits per channel, channel 0 in the low bits |
| hiz | output | 3 | High-impedance enable, one bit per channel |

## Verification
Some properties are checked by assertions on every cycle. Readback must match the tap and `hiz` pins of the selected channel, and any out-of-range pointer must read 00h. The outputs must hold steady inside a busy window, and a busy window must be opened only by a stop. Each commit window must last exactly COMMIT_CYCLES cycles. Other behaviour can only be shown by the bench's scenarios, because it depends on history that no single cycle reveals. That includes the pending slot holding back a write, a newer write replacing an older one, bus input dropped during a commit, discarded out-of-range writes, and the store contents surviving a warm reset. The bench sweeps all 256 setting codes across the three channels and confirms the stored copy by recalling it.

// File: rtl/scc_pkg.sv
package scc_pkg;
   // Controller phases: reload from store, accept bus traffic, timed commit
   typedef enum logic [1:0] {
      ST_RECALL = 2'd0,
      ST_IDLE   = 2'd1,
      ST_COMMIT = 2'd2
   } scc_state_e;
endpackage

// File: rtl/scc_ptr_decode.sv
module scc_ptr_decode #(
   parameter int NUM_CH = 3,
   parameter int PTR_W  = 8,
   parameter int IDX_W  = 2,
   parameter logic [PTR_W-1:0] BASE_PTR = 8'hF8
) (
   input  logic [PTR_W-1:0] ptr,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ptr == PTR_W'(int'(BASE_PTR) + i)) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/scc_commit_timer.sv
module scc_commit_timer #(
   parameter int CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic             running;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (start) begin
         running <= 1'b1;
         cnt     <= CNT_W'(CYCLES - 1);
      end else if (running) begin
         if (cnt == '0) running <= 1'b0;
         else           cnt     <= cnt - 1'b1;
      end
   end

   assign done = running && (cnt == '0);
endmodule

// File: rtl/scc_nv_store.sv
module scc_nv_store #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 2,
   parameter logic [DATA_W-1:0] BLANK = '1
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     we,
   input  logic [IDX_W-1:0]         widx,
   input  logic [DATA_W-1:0]        wdata,
   output logic [NUM_CH*DATA_W-1:0] cells
);
   // One cell per channel; cleared only by power-on, never by system reset
   for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (!por_n)                             cell_q <= BLANK;
         else if (we && widx == IDX_W'(g))       cell_q <= wdata;
      end
      assign cells[g*DATA_W +: DATA_W] = cell_q;
   end
endmodule

// File: rtl/nv_setting_commit.sv
module nv_setting_commit #(
   parameter int NUM_CH        = 3,
   parameter int POS_W         = 7,
   parameter int PTR_W         = 8,
   parameter logic [PTR_W-1:0] BASE_PTR = 8'hF8,
   parameter int COMMIT_CYCLES = 40,
   parameter logic [POS_W:0] BLANK_VAL = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    por_n,
   input  logic                    wr_en,
   input  logic [PTR_W-1:0]        wr_ptr,
   input  logic [POS_W:0]          wr_data,
   input  logic                    bus_stop,
   input  logic [PTR_W-1:0]        rd_ptr,
   output logic [POS_W:0]          rd_data,
   output logic                    busy,
   output logic [NUM_CH*POS_W-1:0] tap_pos,
   output logic [NUM_CH-1:0]       hiz
);
   import scc_pkg::*;

   localparam int DATA_W = POS_W + 1;
   localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1)                                  $error("NUM_CH must be at least 1");
   if (COMMIT_CYCLES < 1)                           $error("COMMIT_CYCLES must be at least 1");
   if (int'(BASE_PTR) + NUM_CH > (1 << PTR_W))      $error("pointer window exceeds PTR_W");

   scc_state_e          st;
   logic                pend_v;
   logic [IDX_W-1:0]    pend_idx;
   logic [DATA_W-1:0]   pend_data;
   logic                wr_hit, rd_hit, tmr_start, tmr_done;
   logic [IDX_W-1:0]    wr_idx, rd_idx;
   logic [NUM_CH*DATA_W-1:0] nv_cells;
   logic [DATA_W-1:0]   act [NUM_CH];

   scc_ptr_decode #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .IDX_W(IDX_W), .BASE_PTR(BASE_PTR))
      u_wr_dec (.ptr(wr_ptr), .hit(wr_hit), .idx(wr_idx));
   scc_ptr_decode #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .IDX_W(IDX_W), .BASE_PTR(BASE_PTR))
      u_rd_dec (.ptr(rd_ptr), .hit(rd_hit), .idx(rd_idx));

   assign tmr_start = (st == ST_IDLE) && bus_stop && pend_v;

   scc_commit_timer #(.CYCLES(COMMIT_CYCLES))
      u_timer (.clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done));

   scc_nv_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W), .BLANK(BLANK_VAL))
      u_store (.clk(clk), .por_n(por_n), .we(tmr_done), .widx(pend_idx),
               .wdata(pend_data), .cells(nv_cells));

   // Phase control and the single pending slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_RECALL;
         pend_v    <= 1'b0;
         pend_idx  <= '0;
         pend_data <= '0;
      end else begin
         unique case (st)
            ST_RECALL: st <= ST_IDLE;
            ST_IDLE: begin
               if (bus_stop && pend_v) begin
                  st     <= ST_COMMIT;
                  pend_v <= 1'b0;
               end else if (wr_en && wr_hit) begin
                  pend_v    <= 1'b1;
                  pend_idx  <= wr_idx;
                  pend_data <= wr_data;
               end
            end
            ST_COMMIT: if (tmr_done) st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);

   // Active settings: reloaded on recall, updated when a commit ends
   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n)
            act[g] <= '0;
         else if (st == ST_RECALL)
            act[g] <= nv_cells[g*DATA_W +: DATA_W];
         else if (tmr_done && pend_idx == IDX_W'(g))
            act[g] <= pend_data;
      end
      assign tap_pos[g*POS_W +: POS_W] = act[g][POS_W-1:0];
      assign hiz[g]                    = act[g][POS_W];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_hit && rd_idx == IDX_W'(i)) rd_data = act[i];
   end
endmodule

// File: rtl/nv_setting_commit_chk.sv
module nv_setting_commit_chk #(
   parameter int NUM_CH        = 3,
   parameter int POS_W         = 7,
   parameter int PTR_W         = 8,
   parameter logic [PTR_W-1:0] BASE_PTR = 8'hF8,
   parameter int COMMIT_CYCLES = 40
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_stop,
   input logic [PTR_W-1:0]        rd_ptr,
   input logic [POS_W:0]          rd_data,
   input logic                    busy,
   input logic [NUM_CH*POS_W-1:0] tap_pos,
   input logic [NUM_CH-1:0]       hiz
);
   localparam int LEN_W = $clog2(COMMIT_CYCLES + 2) + 1;

   logic             rd_in_window;
   logic             busy_q, in_commit;
   logic [LEN_W-1:0] len;

   assign rd_in_window = (int'(rd_ptr) >= int'(BASE_PTR)) &&
                         (int'(rd_ptr) <  int'(BASE_PTR) + NUM_CH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b1;
         in_commit <= 1'b0;
         len       <= '0;
      end else begin
         busy_q <= busy;
         if (busy && !busy_q) begin
            in_commit <= 1'b1;
            len       <= LEN_W'(1);
         end else if (busy) begin
            len <= len + 1'b1;
         end else begin
            in_commit <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_rb
      // R1 R2
      readback_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_ptr == PTR_W'(int'(BASE_PTR) + g)) |->
            (rd_data == {hiz[g], tap_pos[g*POS_W +: POS_W]}));
   end

   // R7
   out_of_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_in_window |-> (rd_data == '0));

   // R4 R6
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(tap_pos) && $stable(hiz)));

   // R5 R8
   busy_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_stop));

   // R5
   commit_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_commit && !busy) |-> (len == LEN_W'(COMMIT_CYCLES)));
endmodule

bind nv_setting_commit nv_setting_commit_chk #(
   .NUM_CH(NUM_CH), .POS_W(POS_W), .PTR_W(PTR_W),
   .BASE_PTR(BASE_PTR), .COMMIT_CYCLES(COMMIT_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .rd_ptr(rd_ptr),
   .rd_data(rd_data), .busy(busy), .tap_pos(tap_pos), .hiz(hiz)
);

// File: tb/nv_setting_commit_test.sv
module nv_setting_commit_test;
   localparam int DLY = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, por_n = 1'b0;
   logic        wr_en = 1'b0, bus_stop = 1'b0;
   logic [7:0]  wr_ptr = '0, wr_data = '0, rd_ptr = '0;
   logic [7:0]  rd_data;
   logic        busy;
   logic [20:0] tap_pos;
   logic [2:0]  hiz;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] exp_act [3];
   logic [7:0] exp_nv  [3];

   always #10 clk = ~clk;

   nv_setting_commit #(.COMMIT_CYCLES(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
      .wr_data(wr_data), .bus_stop(bus_stop), .rd_ptr(rd_ptr), .rd_data(rd_data),
      .busy(busy), .tap_pos(tap_pos), .hiz(hiz));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < 3; c++) begin
         chk({req, " R2 tap"}, 32'(tap_pos[c*7 +: 7]), 32'(exp_act[c][6:0]));
         chk({req, " R3 hiz"}, 32'(hiz[c]), 32'(exp_act[c][7]));
         rd_ptr = 8'hF8 + 8'(c);
         #1;
         chk({req, " R1 readback"}, 32'(rd_data), 32'(exp_act[c]));
      end
      rd_ptr = 8'h00;
   endtask

   task automatic do_write(input logic [7:0] p, input logic [7:0] d);
      wr_en = 1'b1; wr_ptr = p; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic stop_measure(output int n);
      bus_stop = 1'b1;
      @(negedge clk);
      bus_stop = 1'b0;
      n = 0;
      while (busy && n < DLY + 10) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      // cold power-up: store cleared, then recall
      repeat (3) @(negedge clk);
      chk("R9 busy in reset", 32'(busy), 32'd1);
      chk("R9 taps in reset", 32'(tap_pos), 32'd0);
      chk("R9 hiz in reset", 32'(hiz), 32'd0);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy after recall", 32'(busy), 32'd0);
      for (int c = 0; c < 3; c++) begin exp_nv[c] = 8'hFF; exp_act[c] = 8'hFF; end
      check_all("R10 blank recall");

      // R8: stop with nothing pending
      stop_measure(n);
      chk("R8 no commit", 32'(n), 32'd0);

      // R3 R4 R5: sweep every code, rotating channels
      for (int v = 0; v < 256; v++) begin
         int ch;
         ch = v % 3;
         do_write(8'hF8 + 8'(ch), 8'(v));
         chk("R4 busy stays low", 32'(busy), 32'd0);
         check_all("R4 pending invisible");
         stop_measure(n);
         chk("R5 busy length", 32'(n), 32'(DLY));
         exp_act[ch] = 8'(v);
         exp_nv[ch]  = 8'(v);
         check_all("R5 committed");
      end

      // R9: warm reset recalls the stored copy
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy after warm recall", 32'(busy), 32'd0);
      check_all("R9 warm recall");

      // R3 corners: switch low, max tap, high impedance
      do_write(8'hF8, 8'h00); stop_measure(n); exp_act[0] = 8'h00;
      do_write(8'hF9, 8'h7F); stop_measure(n); exp_act[1] = 8'h7F;
      do_write(8'hFA, 8'h80); stop_measure(n); exp_act[2] = 8'h80;
      check_all("R3 corners");

      // R4: newer write replaces older pending one
      do_write(8'hF9, 8'h05);
      do_write(8'hFA, 8'h07);
      stop_measure(n);
      chk("R4 single commit", 32'(n), 32'(DLY));
      exp_act[2] = 8'h07;
      check_all("R4 last write wins");

      // R7: out-of-window writes and reads
      do_write(8'hF7, 8'h33);
      do_write(8'hFB, 8'h44);
      do_write(8'h00, 8'h55);
      stop_measure(n);
      chk("R7 no commit", 32'(n), 32'd0);
      check_all("R7 unchanged");
      rd_ptr = 8'hFB; #1; chk("R7 read FB", 32'(rd_data), 32'd0);
      rd_ptr = 8'hF7; #1; chk("R7 read F7", 32'(rd_data), 32'd0);
      rd_ptr = 8'h00;

      // R6: traffic during a commit is dropped
      do_write(8'hF8, 8'h11);
      bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
      repeat (3) @(negedge clk);
      do_write(8'hF9, 8'h22);
      bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
      n = 0;
      while (busy && n < DLY + 10) begin n++; @(negedge clk); end
      chk("R6 commit window", 32'(n + 5), 32'(DLY));
      exp_act[0] = 8'h11;
      check_all("R6 only first write");
      stop_measure(n);
      chk("R6 write not captured", 32'(n), 32'd0);
      check_all("R6 still unchanged");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule